// File: doc/BRIEF.md
# Asynchronous Serial Port with Read-Then-Clear Status Flags

This block is a byte-wide asynchronous serial transmitter and receiver behind a four-register bus window. Frames are one low start bit, eight data bits sent least significant bit first, an optional even-parity bit, and one high stop bit. The bit rate is fixed by two parameters: a clock divisor that produces an oversampling tick, and the number of ticks per bit (16). The receiver samples each bit at its middle. A finished frame moves from the receive shifter into a receive data register. Software loads a transmit data register, and that register feeds the transmit shifter.

Five status flags report the state of both directions: transmit empty, receive full, framing error, parity error and overrun. A flag can be cleared only by writing 0 to it after a status read has returned it as 1. Two level interrupt outputs, receive-full and receive-error, follow the flags while the receive interrupt enable is set. Transmission starts only after software clears the transmit-empty flag in this way. While transmit is disabled, that flag stays at 1.

Bus map (`bus_addr`): 0 is control (bit0 receive interrupt enable, bit1 transmit enable, bit2 receive enable, bit3 parity enable). 1 is status (bit0 transmit empty, bit1 receive full, bit2 framing error, bit3 parity error, bit4 overrun). 2 is transmit data, which is write only. 3 is receive data, which is read only. `bus_rdata` shows the addressed register combinationally. Writes and reads take effect at the clock edge where `bus_wr` or `bus_rd` is high.

Top module: `uart_flagport`

## Requirements
- R1: After reset the control register reads 0x00, status reads 0x01 (only transmit empty, bit0, set), `txd` is 1 and both interrupt outputs are 0.
- R2: When a frame completes and receive full (status bit1) is 0, the received byte appears at address 3 and bit1 becomes 1. `irq_rx_full` is 1 while bit1 and control bit0 are both 1.
- R3: `irq_rx_err` is 1 exactly while control bit0 is 1 and any of status bits 2, 3 or 4 is 1. Clearing control bit0 drops both interrupt outputs without changing any flag.
- R4: A write of 0 to a status bit clears that bit only if a status read has returned it as 1 since it was last set. A write of 1, or a write of 0 without such a read, leaves the bit unchanged.
- R5: While control bit1 (transmit enable) is 0, status bit0 reads 1 and cannot be cleared.
- R6: With control bit1 at 1, no frame leaves `txd` until the transmit-empty flag is cleared by read-then-write-0. The byte at address 2 is then sent as start 0, data LSB first, stop 1, and bit0 returns to 1 when the shifter loads. `txd` idles at 1.
- R7: While control bit2 (receive enable) is 0, no frame is received. Clearing bit2 leaves status bits 1 to 4 and the receive data unchanged.
- R8: A frame that completes while status bit1 is 1 sets overrun (bit4) and is discarded, so address 3 keeps the earlier byte.
- R9: A frame whose stop bit samples 0 sets framing error (bit2).
- R10: With control bit3 set, an even-parity bit (XOR of the data bits) follows the data on `txd`. A received frame whose parity bit differs from the XOR of its data sets parity error (bit3).
- R11: A low pulse on `rxd` that ends before half a bit time is rejected as a start bit, and no frame is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe; a status read arms flag clearing |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx_full | output | 1 | Receive-full interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |

## Verification
The hardest state to reach is overrun, because it needs a second complete frame on `rxd` while the first byte is still unread. The stimulus therefore sends two frames back to back without touching the status register in between, and then checks that the first byte survives. Flag clearing is tested in its three forms: a write of 0 with no prior read, a write of 1 after a read, and the armed write of 0. A behavioural model tracks the flags and the enable bits, and the interrupt outputs are compared with that model on every clock outside frame reception.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_TXD  = 2'd2,
    A_RXD  = 2'd3
  } reg_addr_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  localparam int unsigned F_TE = 0;
  localparam int unsigned F_RF = 1;
  localparam int unsigned F_FE = 2;
  localparam int unsigned F_PE = 3;
  localparam int unsigned F_OR = 4;
  localparam int unsigned NFLAG = 5;

  // even parity bit: makes the total count of ones even
  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction

endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_flag_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned OS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rx_en,
  input  logic         par_en,
  input  logic         rxd,
  output logic         done,
  output logic [W-1:0] data,
  output logic         stop_bad,
  output logic         par_bad
);
  localparam int unsigned CW = $clog2(OS);
  localparam int unsigned IW = $clog2(W);
  localparam logic [CW-1:0] HALF = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(W - 1);

  logic s1_q, s2_q, s3_q;
  rx_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  sh_q;
  logic par_bit_q, par_en_q;
  logic done_q, stop_bad_q, par_bad_q;
  logic start_edge;

  assign start_edge = s3_q & ~s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; s3_q <= 1'b1;
    end else begin
      s1_q <= rxd; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      par_bit_q <= 1'b0; par_en_q <= 1'b0;
      done_q <= 1'b0; stop_bad_q <= 1'b0; par_bad_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!rx_en) begin
        st_q <= RX_IDLE;
      end else if (st_q == RX_IDLE) begin
        if (start_edge) begin
          st_q <= RX_START; cnt_q <= '0; par_en_q <= par_en;
        end
      end else if (tick) begin
        unique case (st_q)
          RX_START: begin
            if (cnt_q == HALF) begin
              cnt_q <= '0; idx_q <= '0;
              st_q  <= s2_q ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {s2_q, sh_q[W-1:1]};
              if (idx_q == IDX_LAST) st_q <= par_en_q ? RX_PAR : RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0; par_bit_q <= s2_q; st_q <= RX_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q      <= '0;
              done_q     <= 1'b1;
              stop_bad_q <= ~s2_q;
              par_bad_q  <= par_en_q & (par_bit_q != even_par(sh_q));
              st_q       <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done     = done_q;
  assign data     = sh_q;
  assign stop_bad = stop_bad_q;
  assign par_bad  = par_bad_q;

  // R7
  rx_off_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !done_q);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_flag_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned OS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         par_en,
  output logic         txd,
  output logic         busy
);
  localparam int unsigned CW = $clog2(OS);
  localparam int unsigned LW = $clog2(W + 3);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  logic [W+1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] left_q;
  logic busy_q, txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1; cnt_q <= '0; left_q <= '0; busy_q <= 1'b0; txd_q <= 1'b1;
    end else if (load) begin
      sh_q   <= {1'b1, (par_en ? even_par(load_data) : 1'b1), load_data};
      left_q <= par_en ? LW'(W + 2) : LW'(W + 1);
      cnt_q  <= '0;
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (left_q == '0) begin
          busy_q <= 1'b0; txd_q <= 1'b1;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[W+1:1]};
          left_q <= left_q - 1'b1;
        end
      end else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

  // R6
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q);
  // R6
  tx_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/uart_flagport.sv
module uart_flagport
  import uart_flag_pkg::*;
#(
  parameter int unsigned DIV = 4,
  parameter int unsigned OS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_rx_full,
  output logic       irq_rx_err
);
  localparam int unsigned W = 8;

  logic ctl_rie_q, ctl_txe_q, ctl_rxe_q, ctl_par_q;
  logic [NFLAG-1:0] flg_q, arm_q, flg_set, flg_clr;
  logic [W-1:0] tx_data_q, rx_data_q, rx_byte;
  logic tick, rx_done, rx_stop_bad, rx_par_bad, tx_load, tx_busy;
  logic stat_rd, stat_wr;

  uart_os_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  uart_rx_core #(.W(W), .OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(ctl_rxe_q), .par_en(ctl_par_q),
    .rxd(rxd), .done(rx_done), .data(rx_byte), .stop_bad(rx_stop_bad),
    .par_bad(rx_par_bad));

  uart_tx_core #(.W(W), .OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load), .load_data(tx_data_q),
    .par_en(ctl_par_q), .txd(txd), .busy(tx_busy));

  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign tx_load = ctl_txe_q && !flg_q[F_TE] && !tx_busy;

  always_comb begin
    flg_set       = '0;
    flg_set[F_TE] = tx_load | ~ctl_txe_q;
    flg_set[F_RF] = rx_done & ~flg_q[F_RF];
    flg_set[F_FE] = rx_done & rx_stop_bad;
    flg_set[F_PE] = rx_done & rx_par_bad;
    flg_set[F_OR] = rx_done & flg_q[F_RF];
    flg_clr       = {NFLAG{stat_wr}} & ~bus_wdata[NFLAG-1:0] & arm_q;
  end

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flg_q[i] <= (i == F_TE);
          arm_q[i] <= 1'b0;
        end else if (flg_set[i]) begin
          flg_q[i] <= 1'b1; arm_q[i] <= 1'b0;
        end else if (flg_clr[i]) begin
          flg_q[i] <= 1'b0; arm_q[i] <= 1'b0;
        end else if (stat_rd && flg_q[i]) begin
          arm_q[i] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctl_par_q, ctl_rxe_q, ctl_txe_q, ctl_rie_q} <= '0;
      tx_data_q <= '0;
      rx_data_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL)
        {ctl_par_q, ctl_rxe_q, ctl_txe_q, ctl_rie_q} <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_TXD) tx_data_q <= bus_wdata;
      if (flg_set[F_RF]) rx_data_q <= rx_byte;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = {4'b0, ctl_par_q, ctl_rxe_q, ctl_txe_q, ctl_rie_q};
      A_STAT:  bus_rdata = {3'b0, flg_q};
      A_RXD:   bus_rdata = rx_data_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_rx_full = ctl_rie_q & flg_q[F_RF];
  assign irq_rx_err  = ctl_rie_q & (|flg_q[F_OR:F_FE]);

  // R2
  rx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !flg_q[F_RF]) |=> (flg_q[F_RF] && rx_data_q == $past(rx_byte)));
  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && flg_q[F_RF]) |=> (flg_q[F_OR] && $stable(rx_data_q)));
  // R4
  fe_clear_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg_q[F_FE]) |-> $past(arm_q[F_FE]));
  // R6
  tx_load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (flg_q[F_TE] && tx_busy));
  // R5
  te_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_txe_q |=> flg_q[F_TE]);
endmodule

// File: tb/uart_flagport_bench.sv
`timescale 1ns/1ps
module uart_flagport_bench;
  localparam int DIV = 4;
  localparam int OS  = 16;
  localparam int BIT = DIV * OS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic rxd = 1'b1;
  logic txd, irq_rx_full, irq_rx_err;

  always #2.5 clk = ~clk;

  uart_flagport #(.DIV(DIV), .OS(OS)) u_uart_flagport (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err));

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit track = 0;
  // behavioural reference state
  bit m_rie, m_txe, m_rxe, m_par;
  bit [4:0] m_flg = 5'b00001, m_arm = 0;
  bit [7:0] m_rx = 0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && track) begin
    n_tests++;
    if (irq_rx_full !== (m_rie & m_flg[1]) || irq_rx_err !== (m_rie & (|m_flg[4:2]))) begin
      n_fail++;
      $display("FAIL R3 per-cycle irq act=%b%b exp=%b%b", irq_rx_full, irq_rx_err,
               m_rie & m_flg[1], m_rie & (|m_flg[4:2]));
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 2'd0) begin
      {m_par, m_rxe, m_txe, m_rie} = d[3:0];
      if (!m_txe) begin m_flg[0] = 1; m_arm[0] = 0; end
    end else if (a == 2'd1) begin
      for (int i = 0; i < 5; i++)
        if (!d[i] && m_arm[i]) begin m_flg[i] = 0; m_arm[i] = 0; end
      m_flg[0] = 1; m_arm[0] = 0;   // forced or reloaded at once
    end
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    if (a == 2'd1) begin
      m_arm[4:1] = m_arm[4:1] | m_flg[4:1];
      if (m_txe) m_arm[0] = 1;
    end
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic check_stat(input string req);
    logic [7:0] d;
    bus_read(2'd1, d);
    check(req, d, {3'b0, m_flg});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pmode: 0 no parity bit, 1 correct, 2 wrong
  task automatic send_frame(input logic [7:0] d, input bit stop, input int pmode);
    bit pb;
    track = 0;
    pb = ^d;
    @(negedge clk);
    rxd = 0; idle(BIT);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; idle(BIT); end
    if (pmode != 0) begin rxd = (pmode == 1) ? pb : ~pb; idle(BIT); end
    rxd = stop; idle(BIT);
    rxd = 1; idle(4);
    if (m_rxe) begin
      if (m_flg[1]) begin m_flg[4] = 1; m_arm[4] = 0; end
      else begin m_rx = d; m_flg[1] = 1; m_arm[1] = 0; end
      if (!stop) begin m_flg[2] = 1; m_arm[2] = 0; end
      if (pmode == 2) begin m_flg[3] = 1; m_arm[3] = 0; end
    end
    track = 1;
  endtask

  task automatic expect_tx(input string req, input logic [7:0] d, input bit withpar);
    int t = 0;
    while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    check({req, " start seen"}, (t < 4000), 1);
    idle(BIT / 2);
    check({req, " start bit"}, txd, 0);
    for (int i = 0; i < 8; i++) begin idle(BIT); check({req, " data bit"}, txd, d[i]); end
    if (withpar) begin idle(BIT); check({req, " parity bit"}, txd, ^d); end
    idle(BIT); check({req, " stop bit"}, txd, 1);
    idle(BIT);
  endtask

  task automatic txd_quiet(input string req, input int n);
    int lows = 0;
    repeat (n) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check(req, lows, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    bus_read(2'd0, d); check("R1 ctrl", d, 0);
    check_stat("R1 status");
    check("R1 txd", txd, 1);
    check("R1 irqs", {irq_rx_full, irq_rx_err}, 0);
    track = 1;

    // R5 transmit-empty held while transmit disabled
    check_stat("R5 read");
    bus_write(2'd1, 8'h00);
    check_stat("R5 still set");

    // R2 normal reception with interrupt
    bus_write(2'd0, 8'h05);
    send_frame(8'hA5, 1, 0);
    check("R2 irq full", irq_rx_full, 1);
    check_stat("R2 status");
    bus_read(2'd3, d); check("R2 rx data", d, 8'hA5);
    bus_write(2'd1, 8'h00);
    check_stat("R2 cleared");
    check("R2 irq drop", irq_rx_full, 0);

    // R4 clearing rules
    send_frame(8'h3C, 1, 0);
    bus_write(2'd1, 8'h00);          // no prior read
    check_stat("R4 write0 unarmed");
    bus_write(2'd1, 8'hFF);          // armed, but write 1
    check_stat("R4 write1 no effect");
    bus_write(2'd1, 8'h00);
    check_stat("R4 armed clear");

    // R8 overrun and R3 error interrupt
    send_frame(8'h11, 1, 0);
    send_frame(8'h22, 1, 0);
    check_stat("R8 overrun flag");
    bus_read(2'd3, d); check("R8 old byte kept", d, 8'h11);
    check("R3 err irq", irq_rx_err, 1);
    bus_write(2'd0, 8'h04);
    check("R3 enable off", {irq_rx_full, irq_rx_err}, 0);
    check_stat("R3 flags kept");
    bus_write(2'd0, 8'h05);
    check("R3 enable on", {irq_rx_full, irq_rx_err}, 2'b11);
    bus_write(2'd1, 8'h00);
    check_stat("R3 cleared");

    // R9 framing error
    send_frame(8'h5E, 0, 0);
    check_stat("R9 framing");
    check("R9 err irq", irq_rx_err, 1);
    bus_write(2'd1, 8'h00);
    check_stat("R9 cleared");

    // R10 parity receive
    bus_write(2'd0, 8'h0D);
    send_frame(8'h07, 1, 1);
    check_stat("R10 good parity");
    bus_write(2'd1, 8'h00);
    send_frame(8'h81, 1, 2);
    check_stat("R10 bad parity");
    bus_read(2'd3, d); check("R10 data", d, 8'h81);

    // R7 disabling reception keeps flags, blocks frames
    bus_write(2'd0, 8'h01);
    check_stat("R7 flags kept");
    send_frame(8'hF0, 1, 0);
    check_stat("R7 no reception");
    bus_read(2'd3, d); check("R7 data kept", d, 8'h81);
    bus_write(2'd1, 8'h00);
    check_stat("R7 cleared");

    // R11 short low pulse rejected
    bus_write(2'd0, 8'h05);
    @(negedge clk); rxd = 0; idle(3 * DIV); rxd = 1;
    idle(12 * BIT);
    check_stat("R11 glitch ignored");

    // R6 transmit gating and frame
    bus_write(2'd0, 8'h02);
    bus_write(2'd2, 8'h5A);
    txd_quiet("R6 no start on data write", 4 * BIT);
    bus_write(2'd1, 8'hFE);          // write 0 without read: R4
    txd_quiet("R4 tx unarmed clear", 4 * BIT);
    check_stat("R6 empty before clear");
    bus_write(2'd1, 8'hFE);
    expect_tx("R6", 8'h5A, 0);
    check_stat("R6 empty after load");

    // R10 transmit with parity
    bus_write(2'd0, 8'h0A);
    bus_write(2'd2, 8'h07);
    check_stat("R10 tx arm");
    bus_write(2'd1, 8'hFE);
    expect_tx("R10 tx", 8'h07, 1);
    check("R6 idle high", txd, 1);

    track = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule